// File: doc/BRIEF.md
# Byte-Wide Coprocessor Request/Response Link

This block is the host-facing front end of a small floating-point coprocessor. A host that owns only byte-wide parallel ports talks to it over two dedicated 8-bit ports. The host writes requests on one port and reads results on the other, so no line ever changes direction. Each port uses a level-sensitive, fully acknowledged handshake. Every byte is held until the other side confirms it, and the confirmation is itself held until the request level is removed.

A request is nine bytes long. The first byte is an opcode. Operand A follows as four bytes, and then operand B as four bytes, each operand most significant byte first. The block splits each operand into its sign, biased exponent and fraction fields and presents them to the arithmetic units. It then issues a one-cycle start with a two-bit operation select. When the unit reports done, the block captures the 32-bit result and returns it as four bytes, most significant first. It then waits for the next request. An opcode outside the defined set starts no unit and returns zero, so the host always receives a four-byte answer. Input strobes that arrive while a request is being computed or answered are held off until the answer is complete.

Top module: `cop_link`

## Requirements
- R1: After reset, in_ack, out_valid and unit_start are low and the block waits for the first byte of a request.
- R2: A byte is taken only on a high in_strobe while in_ack is low. in_ack then rises, stays high while in_strobe is high, and falls once in_strobe is low. Each strobe level delivers exactly one byte.
- R3: The request byte order is opcode, then A bytes 3..0, then B bytes 3..0 (most significant first). Each operand is presented as sign = bit 31, exponent = bits 30:23 and fraction = bits 22:0.
- R4: Opcodes 0x08, 0x09, 0x0A and 0x0B (add, subtract, multiply, divide) drive unit_op to 0, 1, 2 and 3 respectively. unit_start is high for exactly one cycle after the ninth byte is taken.
- R5: The unit_result value present while unit_done is high is returned as four bytes, bits 31:24 first and bits 7:0 last.
- R6: While out_valid is high and out_ack is low, out_valid stays high and out_data does not change. out_valid falls only after out_ack is seen high. The next byte is presented only after out_ack returns low.
- R7: Any other opcode value starts no unit and is answered with the four bytes 00 00 00 00.
- R8: From the ninth request byte until the fourth result byte is released, a raised in_strobe gets no in_ack. Once the answer is complete, that strobe is taken as the opcode of the next request.
- R9: The request 09 18 36 00 00 1C 12 00 00 presents A = {0, 0x30, 0x360000} and B = {0, 0x38, 0x120000} with the subtract select. Given the unit result 0x9C114A00, it is answered with 9C 11 4A 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Request byte from the host |
| in_strobe | input | 1 | Host level: in_data is valid |
| in_ack | output | 1 | Byte taken; held until in_strobe falls |
| out_data | output | 8 | Result byte to the host |
| out_valid | output | 1 | out_data is valid; held until out_ack |
| out_ack | input | 1 | Host level: result byte taken |
| unit_start | output | 1 | One-cycle start to the selected arithmetic unit |
| unit_op | output | 2 | 0 add, 1 subtract, 2 multiply, 3 divide |
| a_sign | output | 1 | Operand A sign |
| a_exp | output | 8 | Operand A biased exponent |
| a_frac | output | 23 | Operand A fraction |
| b_sign | output | 1 | Operand B sign |
| b_exp | output | 8 | Operand B biased exponent |
| b_frac | output | 23 | Operand B fraction |
| unit_done | input | 1 | Arithmetic unit finished; unit_result is valid |
| unit_result | input | 32 | Packed result word from the unit |

## Verification
A byte counter that is off by one would move operand fields by eight bits. The result would be visible on a_exp and a_frac at the start pulse, or as a start that comes one byte early or late. A sequencer left in the wrong phase would show as a missing answer, an in_ack granted during computation, or an answer that starts before unit_done. Each of these is visible within the same transaction. A transmitter that shifts wrongly or releases a byte early shows on the very next out_data value, or as out_valid falling while out_ack is still low.

// File: rtl/cop_link_pkg.sv
package cop_link_pkg;
   localparam logic [7:0] OPC_ADD = 8'h08;
   localparam logic [7:0] OPC_SUB = 8'h09;
   localparam logic [7:0] OPC_MUL = 8'h0A;
   localparam logic [7:0] OPC_DIV = 8'h0B;

   typedef enum logic [1:0] {
      SEQ_RECV  = 2'd0,
      SEQ_ISSUE = 2'd1,
      SEQ_WAIT  = 2'd2,
      SEQ_SEND  = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      TX_IDLE    = 2'd0,
      TX_PRESENT = 2'd1,
      TX_RELEASE = 2'd2
   } tx_state_t;
endpackage

// File: rtl/cop_link_rx.sv
module cop_link_rx #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_strobe,
   output logic              in_ack,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_ack     <= 1'b0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else begin
         byte_valid <= 1'b0;
         if (!in_ack) begin
            if (enable && in_strobe) begin
               byte_data  <= in_data;
               in_ack     <= 1'b1;
               byte_valid <= 1'b1;
            end
         end else if (!in_strobe) begin
            in_ack <= 1'b0;
         end
      end
   end

   // R2: acknowledge only a strobe that was present
   a_r2_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> $past(in_strobe));
   // R2: acknowledge held while the strobe stays high
   a_r2_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ack && in_strobe) |=> in_ack);
   // R8: nothing is taken while the sequencer is not receiving
   a_r8_no_take_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !in_ack) |=> !in_ack);
endmodule

// File: rtl/cop_link_tx.sv
module cop_link_tx
   import cop_link_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         go,
   input  logic [BYTE_W*WORD_BYTES-1:0] word,
   input  logic                         out_ack,
   output logic [BYTE_W-1:0]            out_data,
   output logic                         out_valid,
   output logic                         done
);
   localparam int WORD_W = BYTE_W * WORD_BYTES;
   localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

   tx_state_t         state;
   logic [WORD_W-1:0] sh;
   logic [IDX_W-1:0]  idx;

   assign out_data = sh[WORD_W-1 -: BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= TX_IDLE;
         sh        <= '0;
         idx       <= '0;
         out_valid <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            TX_IDLE: if (go) begin
               sh        <= word;
               idx       <= '0;
               out_valid <= 1'b1;
               state     <= TX_PRESENT;
            end
            TX_PRESENT: if (out_ack) begin
               out_valid <= 1'b0;
               state     <= TX_RELEASE;
            end
            TX_RELEASE: if (!out_ack) begin
               if (idx == IDX_W'(WORD_BYTES - 1)) begin
                  done  <= 1'b1;
                  state <= TX_IDLE;
               end else begin
                  sh        <= sh << BYTE_W;
                  idx       <= idx + 1'b1;
                  out_valid <= 1'b1;
                  state     <= TX_PRESENT;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   // R6: byte held steady until acknowledged
   a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ack) |=> (out_valid && $stable(out_data)));
   // R6: valid withdrawn only in answer to an acknowledge
   a_r6_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_ack));
endmodule

// File: rtl/cop_link.sv
module cop_link
   import cop_link_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 4,
   parameter int EXP_W      = 8
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [BYTE_W-1:0]                       in_data,
   input  logic                                    in_strobe,
   output logic                                    in_ack,
   output logic [BYTE_W-1:0]                       out_data,
   output logic                                    out_valid,
   input  logic                                    out_ack,
   output logic                                    unit_start,
   output logic [1:0]                              unit_op,
   output logic                                    a_sign,
   output logic [EXP_W-1:0]                        a_exp,
   output logic [BYTE_W*WORD_BYTES-EXP_W-2:0]      a_frac,
   output logic                                    b_sign,
   output logic [EXP_W-1:0]                        b_exp,
   output logic [BYTE_W*WORD_BYTES-EXP_W-2:0]      b_frac,
   input  logic                                    unit_done,
   input  logic [BYTE_W*WORD_BYTES-1:0]            unit_result
);
   localparam int WORD_W    = BYTE_W * WORD_BYTES;
   localparam int FRAC_W    = WORD_W - 1 - EXP_W;
   localparam int REQ_BYTES = 1 + 2 * WORD_BYTES;
   localparam int CNT_W     = $clog2(REQ_BYTES);

   initial begin
      assert (BYTE_W >= 8) else $error("opcode needs a byte of at least 8 bits");
      assert (FRAC_W >= 1) else $error("exponent leaves no fraction bits");
      assert (WORD_BYTES >= 2) else $error("operand must span at least two bytes");
   end

   seq_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] op_q;
   logic [WORD_W-1:0] a_q, b_q, res_q;
   logic              start_q, tx_go, tx_done;
   logic              rx_valid;
   logic [BYTE_W-1:0] rx_byte;
   logic              op_known;

   cop_link_rx #(.BYTE_W(BYTE_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (state == SEQ_RECV),
      .in_data   (in_data),
      .in_strobe (in_strobe),
      .in_ack    (in_ack),
      .byte_valid(rx_valid),
      .byte_data (rx_byte)
   );

   cop_link_tx #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (tx_go),
      .word     (res_q),
      .out_ack  (out_ack),
      .out_data (out_data),
      .out_valid(out_valid),
      .done     (tx_done)
   );

   // opcodes 0x08..0x0B share their upper bits; the low two bits pick the unit
   assign op_known = (op_q[BYTE_W-1:2] == (BYTE_W-2)'(OPC_ADD >> 2));
   assign unit_op  = op_q[1:0];
   assign unit_start = start_q;

   assign {a_sign, a_exp, a_frac} = a_q;
   assign {b_sign, b_exp, b_frac} = b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_RECV;
         cnt     <= '0;
         op_q    <= '0;
         a_q     <= '0;
         b_q     <= '0;
         res_q   <= '0;
         start_q <= 1'b0;
         tx_go   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         tx_go   <= 1'b0;
         case (state)
            SEQ_RECV: if (rx_valid) begin
               if (cnt == '0)
                  op_q <= rx_byte;
               else if (cnt <= CNT_W'(WORD_BYTES))
                  a_q <= {a_q[WORD_W-BYTE_W-1:0], rx_byte};
               else
                  b_q <= {b_q[WORD_W-BYTE_W-1:0], rx_byte};
               if (cnt == CNT_W'(REQ_BYTES - 1)) begin
                  cnt   <= '0;
                  state <= SEQ_ISSUE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_ISSUE: begin
               if (op_known) begin
                  start_q <= 1'b1;
                  state   <= SEQ_WAIT;
               end else begin
                  res_q <= '0;
                  tx_go <= 1'b1;
                  state <= SEQ_SEND;
               end
            end
            SEQ_WAIT: if (unit_done) begin
               res_q <= unit_result;
               tx_go <= 1'b1;
               state <= SEQ_SEND;
            end
            SEQ_SEND: if (tx_done) state <= SEQ_RECV;
            default: state <= SEQ_RECV;
         endcase
      end
   end

   // R4: start lasts exactly one cycle
   a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      unit_start |=> !unit_start);
   // R7: only a defined opcode starts a unit
   a_r7_start_needs_known_op: assert property (@(posedge clk) disable iff (!rst_n)
      unit_start |-> op_known);
   // R8: no answer byte is offered while bytes are still being collected
   a_r8_no_output_while_receiving: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_RECV) |-> !out_valid);
   // R5: the answer begins only once a result word is held
   a_r5_send_after_result: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (state == SEQ_SEND));
endmodule

// File: tb/cop_link_bench.sv
module cop_link_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_strobe = 1'b0;
   logic        in_ack;
   logic [7:0]  out_data;
   logic        out_valid;
   logic        out_ack = 1'b0;
   logic        unit_start;
   logic [1:0]  unit_op;
   logic        a_sign, b_sign;
   logic [7:0]  a_exp, b_exp;
   logic [22:0] a_frac, b_frac;
   logic        unit_done = 1'b0;
   logic [31:0] unit_result = '0;

   int checks = 0;
   int errors = 0;
   int start_cnt = 0;
   logic [1:0]  cap_op;
   logic [31:0] cap_a, cap_b;

   always #5 clk = ~clk;

   cop_link u_cop_link (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_strobe(in_strobe), .in_ack(in_ack),
      .out_data(out_data), .out_valid(out_valid), .out_ack(out_ack),
      .unit_start(unit_start), .unit_op(unit_op),
      .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
      .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
      .unit_done(unit_done), .unit_result(unit_result)
   );

   always @(posedge clk) if (unit_start) begin
      start_cnt <= start_cnt + 1;
      cap_op <= unit_op;
      cap_a  <= {a_sign, a_exp, a_frac};
      cap_b  <= {b_sign, b_exp, b_frac};
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      int n = 0;
      @(negedge clk);
      in_data = b;
      in_strobe = 1'b1;
      while (!in_ack && n < 2000) begin @(negedge clk); n++; end
      in_strobe = 1'b0;
      n = 0;
      while (in_ack && n < 10) begin @(negedge clk); n++; end
      chk(!in_ack, "R2 ack release", {31'd0, in_ack}, 32'd0);
   endtask

   task automatic send_req(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b);
      send_byte(op);
      for (int i = 3; i >= 0; i--) send_byte(a[i*8 +: 8]);
      for (int i = 3; i >= 0; i--) send_byte(b[i*8 +: 8]);
   endtask

   task automatic unit_reply(input logic [31:0] r, input int delay);
      int n = 0;
      while (!unit_start && n < 2000) begin @(negedge clk); n++; end
      repeat (delay) @(negedge clk);
      unit_result = r;
      unit_done = 1'b1;
      @(negedge clk);
      unit_done = 1'b0;
   endtask

   task automatic recv_word(input logic [31:0] exp, input string req);
      for (int i = 3; i >= 0; i--) begin
         int n = 0;
         logic [7:0] b;
         while (!out_valid && n < 2000) begin @(negedge clk); n++; end
         b = out_data;
         repeat (2) @(negedge clk);
         chk(out_valid && out_data == b, "R6 hold before ack", {24'd0, out_data}, {24'd0, b});
         chk(b == exp[i*8 +: 8], req, {24'd0, b}, {24'd0, exp[i*8 +: 8]});
         out_ack = 1'b1;
         n = 0;
         while (out_valid && n < 10) begin @(negedge clk); n++; end
         repeat (2) @(negedge clk);
         chk(!out_valid, "R6 no byte while ack high", {31'd0, out_valid}, 32'd0);
         out_ack = 1'b0;
      end
   endtask

   task automatic t_reset;
      chk(!in_ack && !out_valid && !unit_start, "R1 reset outputs",
          {29'd0, in_ack, out_valid, unit_start}, 32'd0);
   endtask

   task automatic t_example;
      int s0 = start_cnt;
      fork
         send_req(8'h09, 32'h18360000, 32'h1C120000);
         unit_reply(32'h9C114A00, 3);
      join
      chk(start_cnt == s0 + 1, "R4 one start", start_cnt - s0, 1);
      chk(cap_op == 2'd1, "R9 subtract select", {30'd0, cap_op}, 1);
      chk(cap_a == {1'b0, 8'h30, 23'h360000}, "R3 R9 operand A fields", cap_a, 32'h18360000);
      chk(cap_b == {1'b0, 8'h38, 23'h120000}, "R3 R9 operand B fields", cap_b, 32'h1C120000);
      recv_word(32'h9C114A00, "R9 example answer");
   endtask

   task automatic t_all_ops;
      for (int k = 0; k < 4; k++) begin
         logic [31:0] res = {8'h5A + 8'(k), 24'hC3_96_0F};
         logic [31:0] a = 32'hC0490FDB ^ (32'h01010101 * k);
         logic [31:0] b = 32'h3F800000 + 32'(k);
         fork
            send_req(8'h08 + 8'(k), a, b);
            unit_reply(res, k + 1);
         join
         chk(cap_op == 2'(k), "R4 opcode select", {30'd0, cap_op}, k);
         chk(cap_a == a && cap_b == b, "R3 operand order", cap_a ^ cap_b, a ^ b);
         recv_word(res, "R5 result byte order");
      end
   endtask

   task automatic t_unknown_op(input logic [7:0] op);
      int s0 = start_cnt;
      send_req(op, 32'hFFFFFFFF, 32'h12345678);
      recv_word(32'h0, "R7 zero answer");
      chk(start_cnt == s0, "R7 no start", start_cnt - s0, 0);
   endtask

   task automatic t_busy_hold;
      int n = 0;
      fork
         send_req(8'h0A, 32'h18360000, 32'h3F920000);
         begin
            while (!unit_start && n < 2000) begin @(negedge clk); n++; end
            @(negedge clk);
            in_data = 8'h08;
            in_strobe = 1'b1;
            repeat (6) begin
               @(negedge clk);
               chk(!in_ack, "R8 no ack while computing", {31'd0, in_ack}, 0);
            end
            unit_result = 32'h184F9801;
            unit_done = 1'b1;
            @(negedge clk);
            unit_done = 1'b0;
         end
      join
      recv_word(32'h184F9801, "R8 answer while strobe held");
      n = 0;
      while (!in_ack && n < 20) begin @(negedge clk); n++; end
      chk(in_ack, "R8 held strobe taken after answer", {31'd0, in_ack}, 1);
      in_strobe = 1'b0;
      while (in_ack) @(negedge clk);
      fork
         begin
            for (int i = 3; i >= 0; i--) send_byte(8'h40 + 8'(i));
            for (int i = 3; i >= 0; i--) send_byte(8'h20 + 8'(i));
         end
         unit_reply(32'h0BADF00D, 2);
      join
      chk(cap_op == 2'd0, "R8 held byte used as opcode", {30'd0, cap_op}, 0);
      chk(cap_a == 32'h43424140, "R8 following operand", cap_a, 32'h43424140);
      recv_word(32'h0BADF00D, "R8 next answer");
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            repeat (2) @(negedge clk);
            t_reset();
            t_example();
            t_all_ops();
            t_unknown_op(8'h0C);
            t_unknown_op(8'h00);
            t_busy_hold();
         end
         begin
            repeat (100000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule